// File: doc/BRIEF.md
# NMI Status Aggregator

This block gathers six error and event sources into one 32-bit status word. Each source sets its own sticky bit. A separate mask word selects which pending bits may raise the single non-maskable interrupt line to the processor. A mask bit of 0 lets its source through, and a mask bit of 1 blocks it.

Software reaches the block through a small register bus. The bus carries word-aligned reads with byte enables and writes to the mask. Reading the status word clears it, but only when the read includes byte lane 0, which is the lane that holds bit 0.

Five of the sources arrive as one-cycle pulses from neighbouring logic. The external interrupt pin is asynchronous, so the block synchronises it and turns each rising edge into a pulse. An occurrence that arrives while its bit is already pending, or in the same cycle as the clearing read, is never lost.

Top module: `nmi_status_agg`

## Requirements
- R1: After reset the status word reads 0x00000000, the mask word reads 0x0000003F, busRvalid is 0 and nmiOut is 0.
- R2: Each source pulse sets its own status bit, using this layout: bit 0 evtCpuBus, bit 1 evtIbusErr, bit 2 evtIbusTimeout, bit 3 evtMemAddr, bit 4 external interrupt, bit 5 evtRegAccess. Once set, a bit stays set until a clearing read.
- R3: Bits 31:6 of both the status word and the mask word always read as 0. Writing ones to those bits of the mask has no effect.
- R4: A read strobe (busSel=1, busWrite=0) returns busRdata with busRvalid=1 in the following cycle. Byte address 0x0 selects the status word and 0x4 selects the mask word. Any other address reads as 0.
- R5: A status read with busByteEn[0]=1 returns the current value and clears every status bit. A status read with busByteEn[0]=0 returns the value and leaves the status unchanged.
- R6: A source that fires again while its bit is pending keeps the bit at 1. A source that fires after a clear sets the bit again.
- R7: If a source pulses in the same cycle as a clearing read, that read returns the value from before the pulse. The bit for the new pulse is 1 afterwards.
- R8: nmiOut is a register. It equals the OR over all bits of (status AND NOT mask) as held one cycle earlier. It therefore rises one cycle after an unmasked bit sets, and falls one cycle after the clearing read.
- R9: A write to address 0x4 with busByteEn[0]=1 loads mask bits 5:0 from busWdata[5:0]. A mask write with busByteEn[0]=0 changes nothing. A write to the status address changes nothing.
- R10: extNmiAsync passes through a two-flop synchroniser and an edge detector. Each rising edge sets bit 4 once. Holding the pin high does not set the bit again after it has been cleared.
- R11: Back-to-back clearing reads in consecutive cycles work as follows. The second read returns only the events that arrived during the first read's cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Byte address, word aligned |
| busByteEn | input | 4 | Byte lane enables |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid with busRvalid |
| busRvalid | output | 1 | Read data valid, one cycle after the read strobe |
| evtCpuBus | input | 1 | CPU bus error pulse |
| evtIbusErr | input | 1 | Internal bus error pulse |
| evtIbusTimeout | input | 1 | Internal bus timeout pulse |
| evtMemAddr | input | 1 | Memory address error pulse |
| extNmiAsync | input | 1 | Asynchronous external interrupt level |
| evtRegAccess | input | 1 | Illegal register access pulse |
| nmiOut | output | 1 | Registered non-maskable interrupt level |

## Verification
Two functions can act on the same status bit in the same clock edge: the clearing read and the setting of a bit by a new source pulse. The bench provokes this by driving a source pulse together with a clearing read strobe. It also issues two clearing reads in consecutive cycles while a pulse arrives under the first one. The checks confirm that the first read returns the value from before the pulse and that the next read still shows the new bit. A behavioural reference model, updated on every edge, also judges each read result and the interrupt level on every cycle.

// File: rtl/nmi_agg_pkg.sv
package nmi_agg_pkg;

  // Strobes from the bus decoder to the register datapath
  typedef struct packed {
    logic rdAny;      // any read strobe this cycle
    logic rdStatus;   // read of the status word
    logic clrStatus;  // status read that includes byte lane 0
    logic rdMask;     // read of the mask word
    logic wrMask;     // write to the mask word
  } aggStrobes_t;

endpackage

// File: rtl/nmi_agg_ctrl.sv
module nmi_agg_ctrl
  import nmi_agg_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int LANES      = 4,
  parameter int STATUS_OFS = 0,
  parameter int MASK_OFS   = 4
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [LANES-1:0]  busByteEn,
  output aggStrobes_t       strobes
);

  localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(STATUS_OFS);
  localparam logic [ADDR_W-1:0] MASK_A   = ADDR_W'(MASK_OFS);

  logic hitStatus, hitMask, isRead, isWrite;
  logic unusedLow;

  // word aligned: the two low address bits are not decoded
  assign unusedLow = ^{busAddr[1:0], busByteEn[LANES-1:1]};

  assign hitStatus = (busAddr[ADDR_W-1:2] == STATUS_A[ADDR_W-1:2]);
  assign hitMask   = (busAddr[ADDR_W-1:2] == MASK_A[ADDR_W-1:2]);
  assign isRead    = busSel & ~busWrite;
  assign isWrite   = busSel & busWrite;

  always_comb begin
    strobes           = '0;
    strobes.rdAny     = isRead;
    strobes.rdStatus  = isRead & hitStatus;
    strobes.clrStatus = isRead & hitStatus & busByteEn[0];
    strobes.rdMask    = isRead & hitMask;
    strobes.wrMask    = isWrite & hitMask;
  end

endmodule

// File: rtl/nmi_agg_datapath.sv
module nmi_agg_datapath
  import nmi_agg_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NUM_SRC     = 6,
  parameter int SYNC_STAGES = 2,
  parameter int LANES       = DATA_W / 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  aggStrobes_t        strobes,
  input  logic [LANES-1:0]   wrLanes,
  input  logic [NUM_SRC-1:0] wrBits,
  input  logic [NUM_SRC-1:0] pulseEvt,   // synchronous sources, ext slot unused
  input  logic               extNmiAsync,
  input  int unsigned        extSlot,
  output logic [NUM_SRC-1:0] statusQ,
  output logic [NUM_SRC-1:0] maskQ,
  output logic [DATA_W-1:0]  rdataQ,
  output logic               rvalidQ,
  output logic               nmiQ
);

  logic [SYNC_STAGES:0]  extPipe;
  logic                  extPulse;
  logic [NUM_SRC-1:0]    evtVec;
  logic [DATA_W-1:0]     rdSel;

  // synchroniser chain plus one flop for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) extPipe <= '0;
    else       extPipe <= {extPipe[SYNC_STAGES-1:0], extNmiAsync};
  end
  assign extPulse = extPipe[SYNC_STAGES-1] & ~extPipe[SYNC_STAGES];

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign evtVec[i] = (i == int'(extSlot)) ? extPulse : pulseEvt[i];

      // status: new event beats the clear
      always_ff @(posedge clk) begin
        if (!rstN)                 statusQ[i] <= 1'b0;
        else if (evtVec[i])        statusQ[i] <= 1'b1;
        else if (strobes.clrStatus) statusQ[i] <= 1'b0;
      end

      // mask: reset to blocked, written per byte lane
      always_ff @(posedge clk) begin
        if (!rstN)                              maskQ[i] <= 1'b1;
        else if (strobes.wrMask && wrLanes[i/8]) maskQ[i] <= wrBits[i];
      end
    end
  endgenerate

  always_comb begin
    rdSel = '0;
    if (strobes.rdStatus)    rdSel[NUM_SRC-1:0] = statusQ;
    else if (strobes.rdMask) rdSel[NUM_SRC-1:0] = maskQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdataQ  <= '0;
      rvalidQ <= 1'b0;
      nmiQ    <= 1'b0;
    end else begin
      rvalidQ <= strobes.rdAny;
      if (strobes.rdAny) rdataQ <= rdSel;
      nmiQ <= |(statusQ & ~maskQ);
    end
  end

endmodule

// File: rtl/nmi_status_agg.sv
module nmi_status_agg
  import nmi_agg_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 4,
  parameter int NUM_SRC     = 6,
  parameter int SYNC_STAGES = 2,
  parameter int STATUS_OFS  = 0,
  parameter int MASK_OFS    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W/8-1:0] busByteEn,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busRvalid,
  input  logic              evtCpuBus,
  input  logic              evtIbusErr,
  input  logic              evtIbusTimeout,
  input  logic              evtMemAddr,
  input  logic              extNmiAsync,
  input  logic              evtRegAccess,
  output logic              nmiOut
);

  localparam int LANES    = DATA_W / 8;
  localparam int EXT_SLOT = 4;

  aggStrobes_t        strobes;
  logic [NUM_SRC-1:0] pulseEvt;
  logic [NUM_SRC-1:0] statusVal;
  logic [NUM_SRC-1:0] maskVal;
  logic               unusedWdata;

  assign unusedWdata = ^busWdata[DATA_W-1:NUM_SRC];
  assign pulseEvt = {evtRegAccess, 1'b0, evtMemAddr, evtIbusTimeout, evtIbusErr, evtCpuBus};

  nmi_agg_ctrl #(
    .ADDR_W(ADDR_W), .LANES(LANES), .STATUS_OFS(STATUS_OFS), .MASK_OFS(MASK_OFS)
  ) ctrl_i (
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busByteEn(busByteEn), .strobes(strobes)
  );

  nmi_agg_datapath #(
    .DATA_W(DATA_W), .NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES), .LANES(LANES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .wrLanes(busByteEn), .wrBits(busWdata[NUM_SRC-1:0]),
    .pulseEvt(pulseEvt), .extNmiAsync(extNmiAsync), .extSlot(EXT_SLOT),
    .statusQ(statusVal), .maskQ(maskVal),
    .rdataQ(busRdata), .rvalidQ(busRvalid), .nmiQ(nmiOut)
  );

endmodule

// File: rtl/nmi_agg_chk.sv
module nmi_agg_chk #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int NUM_SRC = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               busSel,
  input logic               busWrite,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [DATA_W/8-1:0] busByteEn,
  input logic [DATA_W-1:0]  busRdata,
  input logic               busRvalid,
  input logic               evtCpuBus,
  input logic               nmiOut,
  input logic [NUM_SRC-1:0] statusVal,
  input logic [NUM_SRC-1:0] maskVal
);

  logic armQ;
  logic clrRead;

  always_ff @(posedge clk) begin
    if (!rstN) armQ <= 1'b0;
    else       armQ <= 1'b1;
  end

  assign clrRead = busSel && !busWrite && (busAddr[ADDR_W-1:2] == '0) && busByteEn[0];

  // R4
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite) |=> busRvalid);

  // R4
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armQ && busRvalid) |-> $past(busSel && !busWrite));

  // R3
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRvalid |-> (busRdata[DATA_W-1:NUM_SRC] == '0));

  // R7
  evt_beats_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrRead && evtCpuBus) |=> statusVal[0]);

  // R8
  nmi_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    armQ |-> (nmiOut == $past(|(statusVal & ~maskVal))));

endmodule

bind nmi_status_agg nmi_agg_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC)
) chk_i (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
  .busAddr(busAddr), .busByteEn(busByteEn), .busRdata(busRdata),
  .busRvalid(busRvalid), .evtCpuBus(evtCpuBus), .nmiOut(nmiOut),
  .statusVal(statusVal), .maskVal(maskVal)
);

// File: tb/nmi_status_agg_tb.sv
module nmi_status_agg_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWrite = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [3:0]  busByteEn = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busRvalid, nmiOut;
  logic        evtCpuBus = 0, evtIbusErr = 0, evtIbusTimeout = 0;
  logic        evtMemAddr = 0, extNmiAsync = 0, evtRegAccess = 0;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  nmi_status_agg dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busByteEn(busByteEn), .busWdata(busWdata),
    .busRdata(busRdata), .busRvalid(busRvalid),
    .evtCpuBus(evtCpuBus), .evtIbusErr(evtIbusErr), .evtIbusTimeout(evtIbusTimeout),
    .evtMemAddr(evtMemAddr), .extNmiAsync(extNmiAsync), .evtRegAccess(evtRegAccess),
    .nmiOut(nmiOut)
  );

  // ---------------- behavioural reference model ----------------
  int unsigned mSt = 0, mMk = 63, mRd = 0;
  bit mVal = 0, mNmi = 0;
  bit extHist[$] = '{0, 0, 0};   // [0] newest sample

  always @(posedge clk) begin
    int unsigned ev, nSt, nMk, nRd;
    bit nVal, nNmi, rd, rise;
    if (!rstN) begin
      mSt = 0; mMk = 63; mRd = 0; mVal = 0; mNmi = 0; extHist = '{0, 0, 0};
    end else begin
      rise = extHist[1] && !extHist[2];
      ev = {26'd0, evtRegAccess, rise, evtMemAddr, evtIbusTimeout, evtIbusErr, evtCpuBus};
      rd = busSel && !busWrite;
      nNmi = ((mSt & ~mMk) & 63) != 0;
      nVal = rd;
      nRd = mRd;
      if (rd) nRd = (busAddr[3:2] == 0) ? mSt : (busAddr[3:2] == 1) ? mMk : 0;
      nSt = mSt;
      if (rd && busAddr[3:2] == 0 && busByteEn[0]) nSt = 0;
      nSt = nSt | ev;
      nMk = mMk;
      if (busSel && busWrite && busAddr[3:2] == 1 && busByteEn[0]) nMk = busWdata & 63;
      extHist.push_front(extNmiAsync);
      void'(extHist.pop_back());
      mSt = nSt; mMk = nMk; mRd = nRd; mVal = nVal; mNmi = nNmi;
    end
  end

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R4 model rvalid", busRvalid, mVal);
      chk("R8 model nmiOut", nmiOut, mNmi);
      if (busRvalid) chk("R2 model rdata", busRdata, mRd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic rdReg(input logic [3:0] a, input logic [3:0] be, output logic [31:0] d);
    busSel = 1; busWrite = 0; busAddr = a; busByteEn = be;
    @(negedge clk);
    busSel = 0; busByteEn = 0;
    d = busRdata;
  endtask

  task automatic wrReg(input logic [3:0] a, input logic [3:0] be, input logic [31:0] v);
    busSel = 1; busWrite = 1; busAddr = a; busByteEn = be; busWdata = v;
    @(negedge clk);
    busSel = 0; busWrite = 0; busByteEn = 0; busWdata = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clearAll();
    logic [31:0] d;
    rdReg(4'h0, 4'hF, d);
    idle(2);
  endtask

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected<50000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // ---------------- directed sequence ----------------
  initial begin
    logic [31:0] d;
    idle(3);
    rstN = 1;
    idle(1);
    chk("R1 nmi after reset", nmiOut, 0);
    chk("R1 rvalid after reset", busRvalid, 0);
    rdReg(4'h0, 4'hF, d); chk("R1 status reset", d, 32'h0);
    rdReg(4'h4, 4'hF, d); chk("R1 mask reset", d, 32'h3F);

    // mask writes and lanes
    wrReg(4'h4, 4'hF, 32'hFFFF_FFC0); rdReg(4'h4, 4'hF, d);
    chk("R3 upper mask bits ignored", d, 32'h0);
    wrReg(4'h4, 4'hE, 32'hFFFF_FFFF); rdReg(4'h4, 4'hF, d);
    chk("R9 no lane0 mask write", d, 32'h0);
    rdReg(4'h8, 4'hF, d); chk("R4 unmapped reads zero", d, 32'h0);

    // events, partial reads, clear
    evtCpuBus = 1; evtMemAddr = 1; idle(1); evtCpuBus = 0; evtMemAddr = 0;
    idle(1);
    chk("R8 nmi rises", nmiOut, 1);
    rdReg(4'h0, 4'hE, d); chk("R5 read without lane0", d, 32'h9);
    rdReg(4'h0, 4'h2, d); chk("R5 status kept", d, 32'h9);
    rdReg(4'h0, 4'h1, d); chk("R5 lane0 read value", d, 32'h9);
    rdReg(4'h0, 4'hF, d); chk("R5 cleared", d, 32'h0);
    idle(1);
    chk("R8 nmi falls after clear", nmiOut, 0);

    // every source bit position
    evtIbusErr = 1; idle(1); evtIbusErr = 0;
    evtIbusTimeout = 1; idle(1); evtIbusTimeout = 0;
    evtRegAccess = 1; idle(1); evtRegAccess = 0;
    rdReg(4'h0, 4'h1, d); chk("R2 bits 1 2 5", d, 32'h26);

    // recurrence
    evtIbusErr = 1; idle(1); evtIbusErr = 0; idle(1);
    evtIbusErr = 1; idle(1); evtIbusErr = 0;
    rdReg(4'h0, 4'h1, d); chk("R6 repeat while pending", d, 32'h2);
    evtIbusErr = 1; idle(1); evtIbusErr = 0;
    rdReg(4'h0, 4'h1, d); chk("R6 sets again after clear", d, 32'h2);

    // collision of clear and event
    evtIbusTimeout = 1; idle(1);
    rdReg(4'h0, 4'h1, d);           // pulse still high during this read
    evtIbusTimeout = 0;
    chk("R7 read returns old value", d, 32'h4);
    rdReg(4'h0, 4'h1, d); chk("R7 new event kept", d, 32'h4);

    // back-to-back reads with an event under the first
    evtRegAccess = 1; idle(1); evtRegAccess = 0;
    busSel = 1; busWrite = 0; busAddr = 0; busByteEn = 4'h1; evtCpuBus = 1;
    @(negedge clk);
    evtCpuBus = 0;
    d = busRdata; chk("R11 first read", d, 32'h20);
    @(negedge clk);
    busSel = 0; busByteEn = 0;
    d = busRdata; chk("R11 second read only new", d, 32'h1);

    // status writes ignored
    evtMemAddr = 1; idle(1); evtMemAddr = 0;
    wrReg(4'h0, 4'hF, 32'h0);
    rdReg(4'h0, 4'h1, d); chk("R9 status write ignored", d, 32'h8);

    // external interrupt
    extNmiAsync = 1; idle(5);
    chk("R10 ext raises nmi", nmiOut, 1);
    rdReg(4'h0, 4'h1, d); chk("R10 ext bit", d, 32'h10);
    idle(5);
    rdReg(4'h0, 4'h1, d); chk("R10 held level no repeat", d, 32'h0);
    extNmiAsync = 0; idle(4); extNmiAsync = 1; idle(5);
    rdReg(4'h0, 4'h1, d); chk("R10 second edge", d, 32'h10);
    extNmiAsync = 0; idle(4);

    // masking
    wrReg(4'h4, 4'h1, 32'h3E);
    evtIbusErr = 1; idle(1); evtIbusErr = 0; idle(2);
    chk("R8 masked source silent", nmiOut, 0);
    evtCpuBus = 1; idle(1); evtCpuBus = 0; idle(1);
    chk("R8 unmasked source raises", nmiOut, 1);
    rdReg(4'h4, 4'hF, d); chk("R9 mask readback", d, 32'h3E);
    clearAll();
    chk("R8 low after clear", nmiOut, 0);

    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule